// File: doc/BRIEF.md
# Source Operand Fetch Unit

This unit resolves the source operand of a 16-bit two-operand instruction. A request carries a 4-bit register number, a 2-bit addressing-mode code and a byte/word flag, together with the current contents of the named register and of the program counter (register 0). The unit decides whether the operand is a register value, a generated constant or a memory word. It fetches an extension word if the mode needs one, reads the operand through a single-cycle memory read port with a ready handshake, and returns the result with a one-cycle `done` pulse. Any pointer or program-counter update is returned on a single register write port in that same cycle.

Mode codes are 00 register, 01 indexed, 10 indirect and 11 indirect with post-increment. Register 3, with any mode, and register 2, with modes 10 and 11, produce constants and cause no memory access. Register 2 with mode 01 is absolute addressing, which uses a base of zero. Register 0 with mode 11 is immediate data. Memory addresses are byte addresses. `mem_rdata` is the 16-bit word that holds the addressed byte, with the byte at the odd address in bits 15:8.

The controller has four states. IDLE accepts a request. EXT_FETCH reads the index word at the program counter. OPND_READ reads the operand. DONE presents the result for one cycle.

The transitions are named as follows:
- ACCEPT_SHORT: IDLE to DONE, for a constant, for register mode, or for a misaligned indirect address.
- ACCEPT_INDEX: IDLE to EXT_FETCH.
- ACCEPT_READ: IDLE to OPND_READ.
- INDEX_OK: EXT_FETCH to OPND_READ when ready arrives and the address is aligned.
- INDEX_BAD: EXT_FETCH to DONE when ready arrives and the address is misaligned.
- READ_DONE: OPND_READ to DONE when ready arrives.
- RELEASE: DONE to IDLE.

Top module: `srcop_fetch`

## Requirements
- R1: After reset, `busy`, `done`, `align_err`, `mem_req` and `rf_we` are all 0.
- R2: Mode 00, for any register other than 3, returns `reg_val` with no memory access, and `done` is high in the first cycle after acceptance.
- R3: Register 3 with modes 00, 01, 10 and 11 returns 0x0000, 0x0001, 0x0002 and 0xFFFF. Register 2 with mode 10 returns 0x0004, and with mode 11 returns 0x0008. None of these makes a memory access or a register write.
- R4: Mode 01 on a register other than 2 or 3 reads the index word at the program counter, reads the operand at register plus index, and writes the program counter plus 2 back to register 0. The base register is left unchanged, and `done` comes in the third cycle after acceptance when memory answers at once.
- R5: Register 2 with mode 01 uses the index word alone as the operand address, ignoring the contents of register 2.
- R6: Mode 10 reads the operand at the register contents and makes no register write.
- R7: Mode 11 on a register other than 0, 2 or 3 reads at the register contents and writes that register back incremented by 1 for a byte access or by 2 for a word access.
- R8: Register 0 with mode 11 returns the word at the program counter (its low byte in byte mode) and writes back the program counter plus 2 in both widths.
- R9: A word access (`req_byte`=0) to an odd effective address ends with `align_err`=1 alongside `done` and writes no register, not even the program counter after an index fetch.
- R10: `done` lasts exactly one cycle, and a request raised while `busy` is 1 is ignored.
- R11: In byte mode (`req_byte`=1), the result is the addressed byte zero-extended to 16 bits. For register and constant operands, this byte is the low byte.
- R12: While memory holds `mem_ready` low, `mem_req` and `mem_addr` stay stable and the request completes once ready arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_reg | input | 4 | Source register number |
| req_mode | input | 2 | Addressing-mode code |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| reg_val | input | 16 | Contents of the named register at request time |
| pc_val | input | 16 | Contents of register 0 at request time |
| busy | output | 1 | High outside IDLE |
| done | output | 1 | One-cycle result strobe |
| operand | output | 16 | Resolved operand, valid with done |
| align_err | output | 1 | Misaligned word access, valid with done |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory byte address |
| mem_ready | input | 1 | Memory read data valid |
| mem_rdata | input | 16 | Word containing the addressed byte |
| rf_we | output | 1 | Register write-back enable |
| rf_waddr | output | 4 | Register write-back number |
| rf_wdata | output | 16 | Register write-back value |

## Verification
The hardest case to reach is a misaligned address that only becomes known after the index word arrives. In that case the program-counter advance already queued must be withdrawn. The bench places an odd index at the program counter of an indexed word request and checks that the error appears with no register write and an unchanged program counter. A second hard case is a request raised mid-read. The bench stretches memory with three wait cycles, raises a constant request while the first read is pending, and counts completions afterwards.

// File: rtl/srcop_pkg.sv
package srcop_pkg;

    // Addressing-mode codes carried by the instruction
    localparam logic [1:0] AM_DIRECT  = 2'b00;
    localparam logic [1:0] AM_OFFSET  = 2'b01;
    localparam logic [1:0] AM_POINTER = 2'b10;
    localparam logic [1:0] AM_POSTINC = 2'b11;

    // Operand class after decoding register number and mode
    typedef enum logic [2:0] {
        KIND_CONST,
        KIND_REG,
        KIND_INDEX,
        KIND_INDIR,
        KIND_POSTINC
    } src_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXT_FETCH,
        ST_OPND_READ,
        ST_DONE
    } fetch_state_e;

endpackage

// File: rtl/srcop_decode.sv
module srcop_decode
    import srcop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_AW = 4,
    parameter int SR_NUM = 2,
    parameter int CG_NUM = 3
) (
    input  logic [REG_AW-1:0] regnum,
    input  logic [1:0]        mode,
    output src_kind_e         kind,
    output logic [DATA_W-1:0] cval,
    output logic              zero_base
);

    localparam logic [REG_AW-1:0] SR_ID = REG_AW'(SR_NUM);
    localparam logic [REG_AW-1:0] CG_ID = REG_AW'(CG_NUM);

    always_comb begin
        kind      = KIND_REG;
        cval      = '0;
        zero_base = 1'b0;
        if (regnum == CG_ID) begin
            kind = KIND_CONST;
            unique case (mode)
                AM_DIRECT:  cval = '0;
                AM_OFFSET:  cval = DATA_W'(1);
                AM_POINTER: cval = DATA_W'(2);
                AM_POSTINC: cval = '1;
            endcase
        end else if (regnum == SR_ID) begin
            unique case (mode)
                AM_DIRECT:  kind = KIND_REG;
                AM_OFFSET: begin
                    kind      = KIND_INDEX;
                    zero_base = 1'b1;
                end
                AM_POINTER: begin
                    kind = KIND_CONST;
                    cval = DATA_W'(4);
                end
                AM_POSTINC: begin
                    kind = KIND_CONST;
                    cval = DATA_W'(8);
                end
            endcase
        end else begin
            unique case (mode)
                AM_DIRECT:  kind = KIND_REG;
                AM_OFFSET:  kind = KIND_INDEX;
                AM_POINTER: kind = KIND_INDIR;
                AM_POSTINC: kind = KIND_POSTINC;
            endcase
        end
    end

endmodule

// File: rtl/srcop_lane.sv
module srcop_lane #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word,
    input  logic              lane_hi,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] value
);

    localparam int HALF = DATA_W / 2;

    logic [HALF-1:0] picked;

    always_comb begin
        picked = lane_hi ? word[DATA_W-1:HALF] : word[HALF-1:0];
        value  = byte_mode ? {{(DATA_W-HALF){1'b0}}, picked} : word;
    end

endmodule

// File: rtl/srcop_step.sv
module srcop_step #(
    parameter int DATA_W = 16,
    parameter int REG_AW = 4,
    parameter int PC_NUM = 0
) (
    input  logic [DATA_W-1:0] base,
    input  logic [REG_AW-1:0] regnum,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] addr_cand,
    output logic [DATA_W-1:0] ptr_next,
    output logic              misalign
);

    localparam logic [REG_AW-1:0] PC_ID = REG_AW'(PC_NUM);

    logic single_step;

    always_comb begin
        // The program counter always moves a whole word
        single_step = byte_mode && (regnum != PC_ID);
        ptr_next    = base + (single_step ? DATA_W'(1) : DATA_W'(2));
        misalign    = !byte_mode && addr_cand[0];
    end

endmodule

// File: rtl/srcop_fetch.sv
module srcop_fetch
    import srcop_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int REG_AW = 4,
    parameter int PC_NUM = 0,
    parameter int SR_NUM = 2,
    parameter int CG_NUM = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [REG_AW-1:0] req_reg,
    input  logic [1:0]        req_mode,
    input  logic              req_byte,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [DATA_W-1:0] pc_val,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] operand,
    output logic              align_err,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rf_we,
    output logic [REG_AW-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata
);

    localparam logic [REG_AW-1:0] PC_ID = REG_AW'(PC_NUM);

    fetch_state_e      state_q, state_d;
    logic              byte_q;
    logic [DATA_W-1:0] base_q;
    logic [DATA_W-1:0] pc_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] operand_q;
    logic              err_q;
    logic              wb_en_q;
    logic [REG_AW-1:0] wb_addr_q;
    logic [DATA_W-1:0] wb_data_q;

    src_kind_e         dec_kind;
    logic [DATA_W-1:0] dec_cval;
    logic              dec_zero_base;
    logic [DATA_W-1:0] base_now;
    logic [DATA_W-1:0] addr_cand;
    logic [DATA_W-1:0] ptr_next;
    logic              misalign;
    logic [DATA_W-1:0] lane_word;
    logic              lane_hi;
    logic              lane_byte;
    logic [DATA_W-1:0] lane_val;
    logic              accept;

    srcop_decode #(
        .DATA_W(DATA_W), .REG_AW(REG_AW), .SR_NUM(SR_NUM), .CG_NUM(CG_NUM)
    ) decode_i (
        .regnum    (req_reg),
        .mode      (req_mode),
        .kind      (dec_kind),
        .cval      (dec_cval),
        .zero_base (dec_zero_base)
    );

    // Address candidate: register contents at accept, base plus index after the fetch
    always_comb begin
        base_now  = dec_zero_base ? '0 : reg_val;
        addr_cand = (state_q == ST_EXT_FETCH) ? (base_q + mem_rdata) : base_now;
        lane_byte = (state_q == ST_IDLE) ? req_byte : byte_q;
    end

    srcop_step #(
        .DATA_W(DATA_W), .REG_AW(REG_AW), .PC_NUM(PC_NUM)
    ) step_i (
        .base      (base_now),
        .regnum    (req_reg),
        .byte_mode (lane_byte),
        .addr_cand (addr_cand),
        .ptr_next  (ptr_next),
        .misalign  (misalign)
    );

    // One lane selector serves register, constant and memory operands
    always_comb begin
        if (state_q == ST_OPND_READ) begin
            lane_word = mem_rdata;
            lane_hi   = addr_q[0];
        end else begin
            lane_word = (dec_kind == KIND_CONST) ? dec_cval : reg_val;
            lane_hi   = 1'b0;
        end
    end

    srcop_lane #(
        .DATA_W(DATA_W)
    ) lane_i (
        .word      (lane_word),
        .lane_hi   (lane_hi),
        .byte_mode (lane_byte),
        .value     (lane_val)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    unique case (dec_kind)
                        KIND_CONST, KIND_REG: state_d = ST_DONE;       // ACCEPT_SHORT
                        KIND_INDEX:           state_d = ST_EXT_FETCH;  // ACCEPT_INDEX
                        KIND_INDIR, KIND_POSTINC:
                            state_d = misalign ? ST_DONE : ST_OPND_READ; // ACCEPT_SHORT / ACCEPT_READ
                    endcase
                end
            end
            ST_EXT_FETCH: begin
                if (mem_ready) begin
                    state_d = misalign ? ST_DONE : ST_OPND_READ;        // INDEX_BAD / INDEX_OK
                end
            end
            ST_OPND_READ: begin
                if (mem_ready) begin
                    state_d = ST_DONE;                                  // READ_DONE
                end
            end
            ST_DONE: state_d = ST_IDLE;                                 // RELEASE
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q    <= 1'b0;
            base_q    <= '0;
            pc_q      <= '0;
            addr_q    <= '0;
            operand_q <= '0;
            err_q     <= 1'b0;
            wb_en_q   <= 1'b0;
            wb_addr_q <= '0;
            wb_data_q <= '0;
        end else if (accept) begin
            byte_q    <= req_byte;
            base_q    <= base_now;
            pc_q      <= pc_val;
            addr_q    <= base_now;
            operand_q <= '0;
            err_q     <= 1'b0;
            wb_en_q   <= 1'b0;
            wb_addr_q <= req_reg;
            wb_data_q <= ptr_next;
            unique case (dec_kind)
                KIND_CONST, KIND_REG: begin
                    operand_q <= lane_val;
                end
                KIND_INDEX: begin
                    wb_en_q   <= 1'b1;
                    wb_addr_q <= PC_ID;
                    wb_data_q <= pc_val + DATA_W'(2);
                end
                KIND_INDIR: begin
                    err_q <= misalign;
                end
                KIND_POSTINC: begin
                    err_q   <= misalign;
                    wb_en_q <= !misalign;
                end
            endcase
        end else if (state_q == ST_EXT_FETCH && mem_ready) begin
            addr_q <= addr_cand;
            if (misalign) begin
                err_q   <= 1'b1;
                wb_en_q <= 1'b0;
            end
        end else if (state_q == ST_OPND_READ && mem_ready) begin
            operand_q <= lane_val;
        end
    end

    // Outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        operand   = operand_q;
        align_err = done && err_q;
        mem_req   = (state_q == ST_EXT_FETCH) || (state_q == ST_OPND_READ);
        mem_addr  = (state_q == ST_EXT_FETCH) ? pc_q : addr_q;
        rf_we     = done && wb_en_q;
        rf_waddr  = wb_addr_q;
        rf_wdata  = wb_data_q;
    end

endmodule

// File: rtl/srcop_fetch_chk.sv
module srcop_fetch_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              align_err,
    input logic              mem_req,
    input logic              mem_ready,
    input logic [DATA_W-1:0] mem_addr,
    input logic              rf_we
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy && !mem_req); // R10

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !rf_we); // R9

    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> done); // R9

    AST_WRITE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> done); // R7

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R12

endmodule

bind srcop_fetch srcop_fetch_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .align_err (align_err),
    .mem_req   (mem_req),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .rf_we     (rf_we)
);

// File: tb/srcop_fetch_tb_top.sv
`timescale 1ns/1ps
module srcop_fetch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_reg = '0;
    logic [1:0]  req_mode = '0;
    logic        req_byte = 1'b0;
    logic [15:0] reg_val, pc_val;
    logic        busy, done, align_err, mem_req, mem_ready, rf_we;
    logic [15:0] operand, mem_addr, mem_rdata, rf_wdata;
    logic [3:0]  rf_waddr;

    logic [15:0] regs [16];
    logic [15:0] mem  [64];
    int          wait_cfg = 0;
    int          wcnt = 0;
    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    int          mem_cnt = 0;
    int          wr_cnt = 0;
    int          done_cnt = 0;

    logic [15:0] res_op;
    logic        res_err;
    int          res_lat, res_mem, res_wr;

    always #4 clk = ~clk;   // 125 MHz

    assign reg_val   = regs[req_reg];
    assign pc_val    = regs[0];
    assign mem_rdata = mem[mem_addr[6:1]];
    assign mem_ready = mem_req && (wcnt >= wait_cfg);

    srcop_fetch dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_reg(req_reg),
        .req_mode(req_mode), .req_byte(req_byte), .reg_val(reg_val), .pc_val(pc_val),
        .busy(busy), .done(done), .operand(operand), .align_err(align_err),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata)
    );

    always @(posedge clk) begin
        if (mem_req && !mem_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (mem_req && mem_ready) mem_cnt <= mem_cnt + 1;
        if (rf_we) begin
            regs[rf_waddr] <= rf_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected <100000 cycles", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] r, input logic [1:0] m, input logic b);
        int m0, w0;
        @(negedge clk);
        m0 = mem_cnt; w0 = wr_cnt;
        req_reg = r; req_mode = m; req_byte = b; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        res_lat = 1;
        while (!done && res_lat < 40) begin
            @(negedge clk);
            res_lat++;
        end
        if (!done) begin
            errors = errors + 1;
            $display("FAIL R10 actual no done expected done");
        end
        res_op  = operand;
        res_err = align_err;
        @(negedge clk);   // write-back applied, done must be low again
        chk("R10 done single cycle", 16'(done), 16'd0);
        res_mem = mem_cnt - m0;
        res_wr  = wr_cnt - w0;
    endtask

    task automatic t_reset();
        chk("R1 busy", 16'(busy), 0);
        chk("R1 done", 16'(done), 0);
        chk("R1 align_err", 16'(align_err), 0);
        chk("R1 mem_req", 16'(mem_req), 0);
        chk("R1 rf_we", 16'(rf_we), 0);
    endtask

    task automatic t_register();
        regs[5] = 16'h8A3C;
        do_op(4'd5, 2'b00, 1'b0);
        chk("R2 value", res_op, 16'h8A3C);
        chk("R2 latency", 16'(res_lat), 1);
        chk("R2 no mem", 16'(res_mem), 0);
        do_op(4'd5, 2'b00, 1'b1);
        chk("R11 reg byte", res_op, 16'h003C);
        regs[0] = 16'h0120;
        do_op(4'd0, 2'b00, 1'b0);
        chk("R2 pc direct", res_op, 16'h0120);
    endtask

    task automatic t_const();
        logic [15:0] exp_c [4] = '{16'h0000, 16'h0001, 16'h0002, 16'hFFFF};
        regs[3] = 16'h7777;
        regs[2] = 16'h0105;
        for (int m = 0; m < 4; m++) begin
            do_op(4'd3, 2'(m), 1'b0);
            chk("R3 r3 const", res_op, exp_c[m]);
            chk("R3 r3 no mem", 16'(res_mem + res_wr), 0);
        end
        do_op(4'd2, 2'b10, 1'b0);
        chk("R3 r2 four", res_op, 16'h0004);
        do_op(4'd2, 2'b11, 1'b0);
        chk("R3 r2 eight", res_op, 16'h0008);
        chk("R3 r2 no mem", 16'(res_mem + res_wr), 0);
        do_op(4'd3, 2'b11, 1'b1);
        chk("R11 const byte", res_op, 16'h00FF);
    endtask

    task automatic t_indexed();
        regs[0] = 16'h0040; mem[16'h0040 >> 1] = 16'h0006; regs[5] = 16'h0010;
        do_op(4'd5, 2'b01, 1'b0);
        chk("R4 operand", res_op, mem[16'h0016 >> 1]);
        chk("R4 latency", 16'(res_lat), 3);
        chk("R4 pc advanced", regs[0], 16'h0042);
        chk("R4 base kept", regs[5], 16'h0010);
        chk("R4 mem reads", 16'(res_mem), 2);
        regs[2] = 16'hFFF1; mem[16'h0042 >> 1] = 16'h0030;
        do_op(4'd2, 2'b01, 1'b0);
        chk("R5 absolute", res_op, mem[16'h0030 >> 1]);
        chk("R5 pc advanced", regs[0], 16'h0044);
    endtask

    task automatic t_indirect();
        regs[6] = 16'h0024;
        do_op(4'd6, 2'b10, 1'b0);
        chk("R6 operand", res_op, mem[16'h0024 >> 1]);
        chk("R6 no write", 16'(res_wr), 0);
        chk("R6 reg kept", regs[6], 16'h0024);
        chk("R6 no error", 16'(res_err), 0);
    endtask

    task automatic t_postinc();
        logic [15:0] w;
        regs[7] = 16'h0028;
        do_op(4'd7, 2'b11, 1'b0);
        chk("R7 word operand", res_op, mem[16'h0028 >> 1]);
        chk("R7 word step", regs[7], 16'h002A);
        regs[7] = 16'h002B;
        w = mem[16'h002B >> 1];
        do_op(4'd7, 2'b11, 1'b1);
        chk("R11 odd byte", res_op, {8'h00, w[15:8]});
        chk("R7 byte step", regs[7], 16'h002C);
    endtask

    task automatic t_immediate();
        logic [15:0] w;
        regs[0] = 16'h0050;
        do_op(4'd0, 2'b11, 1'b0);
        chk("R8 imm word", res_op, mem[16'h0050 >> 1]);
        chk("R8 pc word", regs[0], 16'h0052);
        w = mem[16'h0052 >> 1];
        do_op(4'd0, 2'b11, 1'b1);
        chk("R8 imm byte", res_op, {8'h00, w[7:0]});
        chk("R8 pc byte", regs[0], 16'h0054);
    endtask

    task automatic t_align();
        regs[6] = 16'h0025;
        do_op(4'd6, 2'b10, 1'b0);
        chk("R9 indirect err", 16'(res_err), 1);
        chk("R9 indirect latency", 16'(res_lat), 1);
        regs[7] = 16'h0031;
        do_op(4'd7, 2'b11, 1'b0);
        chk("R9 postinc err", 16'(res_err), 1);
        chk("R9 postinc kept", regs[7], 16'h0031);
        regs[0] = 16'h0060; mem[16'h0060 >> 1] = 16'h0007; regs[5] = 16'h0010;
        do_op(4'd5, 2'b01, 1'b0);
        chk("R9 index err", 16'(res_err), 1);
        chk("R9 pc kept", regs[0], 16'h0060);
        chk("R9 no writes", 16'(res_wr), 0);
        regs[7] = 16'h0031;
        do_op(4'd7, 2'b11, 1'b1);
        chk("R9 byte odd ok", 16'(res_err), 0);
    endtask

    task automatic t_busy_wait();
        int d0, lat;
        logic [15:0] got;
        wait_cfg = 3;
        regs[6] = 16'h0024;
        @(negedge clk);
        d0 = done_cnt;
        req_reg = 4'd6; req_mode = 2'b10; req_byte = 1'b0; req_valid = 1'b1;
        @(negedge clk);
        // busy now: raise a constant request that must be dropped
        req_reg = 4'd3; req_mode = 2'b01; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 2;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        got = operand;
        chk("R12 wait latency", 16'(lat), 5);
        chk("R12 operand", got, mem[16'h0024 >> 1]);
        repeat (8) @(negedge clk);
        chk("R10 single completion", 16'(done_cnt - d0), 1);
        chk("R10 idle after", 16'(busy), 0);
        wait_cfg = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 16'(i * 16'h0111);
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0305 + 16'h4C17);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_register();
        t_const();
        t_indexed();
        t_indirect();
        t_postinc();
        t_immediate();
        t_align();
        t_busy_wait();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule